// File: doc/BRIEF.md
# Serial Programming Port for a Synthesiser

This block takes a three-wire serial word (a strobe, a bit clock and a data line) from a host controller. It turns that word into the divider settings of a frequency synthesiser. All three pins are asynchronous to the fast system clock. Each pin passes through a multi-stage synchroniser, and its edges are found in the system clock domain. While the strobe is high, every falling bit-clock edge shifts one data bit in. The bits arrive MSB first, grouped as a 7-bit swallow value, a 10-bit main value, a 2-bit band value and an 11-bit reference value. That gives 30 bits in all.

When the strobe falls, the received fields are committed to the holding registers that drive the dividers. A complete 30-bit word updates all four registers. A shortened word of 19 to 29 bits updates only the swallow, main and band registers, using the first 19 bits received. It leaves the reference setting untouched, so a stray clock burst cannot corrupt the reference divider. A word shorter than 19 bits is dropped. Every accepted commit raises a one-cycle strobe, which the dividers and phase detectors use to realign. A second strobe marks commits that also reloaded the reference value.

Top module: `synth_serial_loader`

## Requirements
- R1: After reset, the swallow, main, band and reference outputs are all zero, and neither strobe is high.
- R2: While the strobe pin is high, each falling edge of the bit clock takes in one data bit. In a full word, bits 1-7 form the swallow value, bits 8-17 the main value, bits 18-19 the band value and bits 20-30. Each field arrives MSB first. When the strobe falls after 30 counted edges, all four outputs take the new fields.
- R3: When 19 to 29 edges were counted, the swallow, main and band outputs take bits 1-19, and the reference output keeps its old value.
- R4: When fewer than 19 edges were counted, no output changes and neither strobe pulses.
- R5: Bit-clock edges after the 30th within one strobe window are ignored. The committed fields are those of the first 30 bits.
- R6: While the strobe pin is low, activity on the bit clock and data pins changes no output and raises no strobe.
- R7: band_o[1] carries the first band bit received and band_o[0] the second.
- R8: sync_pulse is high for exactly one cycle per accepted commit of 19 or more bits. r_load_pulse is high for exactly one cycle, only on 30-bit commits, and only together with sync_pulse.
- R9: A bit-clock fall that reaches the system domain in the same cycle as the strobe fall is not counted.
- R10: The swallow, main, band and reference outputs change only in a cycle where sync_pulse is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_en | input | 1 | Serial strobe; shifting is allowed while high, commit happens on its fall |
| ser_clk | input | 1 | Serial bit clock; data is taken on its falling edge |
| ser_dat | input | 1 | Serial data, MSB first |
| swallow_o | output | 7 | Committed swallow-counter value |
| main_o | output | 10 | Committed main-counter value |
| band_o | output | 2 | Committed band value |
| ref_o | output | 11 | Committed reference-divider value |
| sync_pulse | output | 1 | One-cycle strobe on every accepted commit |
| r_load_pulse | output | 1 | One-cycle strobe on commits that reloaded the reference value |

## Verification
Counting a bit-clock edge and committing on the strobe fall can land in the same system cycle. This happens when the host drops the bit clock and the strobe together. Both pins cross identical synchroniser chains, so their falls are detected together. The bench provokes this by releasing both pins on the same stimulus step, once at 19 bits and once at 30 bits. The 19-bit word must then be dropped with no strobe. The 30-bit word must commit as a short update, and the reference output must stay unchanged.

// File: rtl/synth_serial_loader_pkg.sv
package synth_serial_loader_pkg;
   // outcome of a strobe fall, decided from the number of counted bits
   typedef enum logic [1:0] {
      FRAME_DROP  = 2'd0,
      FRAME_SHORT = 2'd1,
      FRAME_FULL  = 2'd2
   } frame_kind_e;
endpackage

// File: rtl/ssl_pin_sync.sv
module ssl_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic level,
   output logic fall
);
   logic [STAGES-1:0] chain;
   logic              last;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("ssl_pin_sync needs at least two stages");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
         last  <= 1'b0;
      end else begin
         chain <= {chain[STAGES-2:0], pin};
         last  <= chain[STAGES-1];
      end
   end

   assign level = chain[STAGES-1];
   assign fall  = last & ~chain[STAGES-1];
endmodule

// File: rtl/ssl_frame_shifter.sv
module ssl_frame_shifter #(
   parameter int HEAD_W = 19,
   parameter int TAIL_W = 11,
   parameter int CNT_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take_bit,
   input  logic              dat,
   input  logic              clear,
   output logic [HEAD_W-1:0] head,
   output logic [TAIL_W-1:0] tail,
   output logic [CNT_W-1:0]  count
);
   localparam int FULL_LEN = HEAD_W + TAIL_W;
   localparam logic [CNT_W-1:0] HEAD_LIM = CNT_W'(HEAD_W);
   localparam logic [CNT_W-1:0] FULL_LIM = CNT_W'(FULL_LEN);

   logic in_head, in_tail, room;

   assign room    = (count < FULL_LIM);
   assign in_head = (count < HEAD_LIM);
   assign in_tail = room & ~in_head;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (clear) begin
         count <= '0;
      end else if (take_bit && room) begin
         count <= count + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head <= '0;
      end else if (take_bit && in_head) begin
         head <= {head[HEAD_W-2:0], dat};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tail <= '0;
      end else if (take_bit && in_tail) begin
         tail <= {tail[TAIL_W-2:0], dat};
      end
   end
endmodule

// File: rtl/ssl_commit.sv
module ssl_commit
   import synth_serial_loader_pkg::*;
#(
   parameter int A_W   = 7,
   parameter int M_W   = 10,
   parameter int B_W   = 2,
   parameter int R_W   = 11,
   parameter int CNT_W = 5
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     commit,
   input  logic [CNT_W-1:0]         count,
   input  logic [A_W+M_W+B_W-1:0]   head,
   input  logic [R_W-1:0]           tail,
   output logic [A_W-1:0]           a_q,
   output logic [M_W-1:0]           m_q,
   output logic [B_W-1:0]           b_q,
   output logic [R_W-1:0]           r_q,
   output logic                     sync_q,
   output logic                     rload_q
);
   localparam int HEAD_W = A_W + M_W + B_W;
   localparam logic [CNT_W-1:0] HEAD_LIM = CNT_W'(HEAD_W);
   localparam logic [CNT_W-1:0] FULL_LIM = CNT_W'(HEAD_W + R_W);

   frame_kind_e kind;

   always_comb begin
      if (count == FULL_LIM)      kind = FRAME_FULL;
      else if (count >= HEAD_LIM) kind = FRAME_SHORT;
      else                        kind = FRAME_DROP;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q     <= '0;
         m_q     <= '0;
         b_q     <= '0;
         r_q     <= '0;
         sync_q  <= 1'b0;
         rload_q <= 1'b0;
      end else begin
         sync_q  <= 1'b0;
         rload_q <= 1'b0;
         if (commit && kind != FRAME_DROP) begin
            a_q    <= head[HEAD_W-1 -: A_W];
            m_q    <= head[HEAD_W-1-A_W -: M_W];
            b_q    <= head[B_W-1:0];
            sync_q <= 1'b1;
            if (kind == FRAME_FULL) begin
               r_q     <= tail;
               rload_q <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/synth_serial_loader.sv
module synth_serial_loader #(
   parameter int A_W         = 7,
   parameter int M_W         = 10,
   parameter int B_W         = 2,
   parameter int R_W         = 11,
   parameter int SYNC_STAGES = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           ser_en,
   input  logic           ser_clk,
   input  logic           ser_dat,
   output logic [A_W-1:0] swallow_o,
   output logic [M_W-1:0] main_o,
   output logic [B_W-1:0] band_o,
   output logic [R_W-1:0] ref_o,
   output logic           sync_pulse,
   output logic           r_load_pulse
);
   localparam int HEAD_W   = A_W + M_W + B_W;
   localparam int FULL_LEN = HEAD_W + R_W;
   localparam int CNT_W    = $clog2(FULL_LEN + 1);

   generate
      if (A_W < 1 || M_W < 1 || B_W < 1 || R_W < 2) begin : g_bad_fields
         $error("synth_serial_loader field widths out of range");
      end
   endgenerate

   logic en_lvl, en_fall, ck_lvl, ck_fall, dat_lvl, dat_fall;
   logic [HEAD_W-1:0] head;
   logic [R_W-1:0]    tail;
   logic [CNT_W-1:0]  count;

   ssl_pin_sync #(.STAGES(SYNC_STAGES)) u_sync_en (
      .clk(clk), .rst_n(rst_n), .pin(ser_en),  .level(en_lvl),  .fall(en_fall));
   ssl_pin_sync #(.STAGES(SYNC_STAGES)) u_sync_ck (
      .clk(clk), .rst_n(rst_n), .pin(ser_clk), .level(ck_lvl),  .fall(ck_fall));
   ssl_pin_sync #(.STAGES(SYNC_STAGES)) u_sync_dt (
      .clk(clk), .rst_n(rst_n), .pin(ser_dat), .level(dat_lvl), .fall(dat_fall));

   logic take_bit, unused_ok;
   // a bit-clock fall counts only while the synchronised strobe is still high
   assign take_bit  = ck_fall & en_lvl;
   assign unused_ok = ck_lvl ^ dat_fall;

   ssl_frame_shifter #(.HEAD_W(HEAD_W), .TAIL_W(R_W), .CNT_W(CNT_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .take_bit(take_bit), .dat(dat_lvl),
      .clear(en_fall), .head(head), .tail(tail), .count(count));

   ssl_commit #(.A_W(A_W), .M_W(M_W), .B_W(B_W), .R_W(R_W), .CNT_W(CNT_W)) u_commit (
      .clk(clk), .rst_n(rst_n), .commit(en_fall), .count(count),
      .head(head), .tail(tail), .a_q(swallow_o), .m_q(main_o), .b_q(band_o),
      .r_q(ref_o), .sync_q(sync_pulse), .rload_q(r_load_pulse));
endmodule

// File: rtl/synth_serial_loader_chk.sv
module synth_serial_loader_chk #(
   parameter int A_W = 7,
   parameter int M_W = 10,
   parameter int B_W = 2,
   parameter int R_W = 11
) (
   input logic           clk,
   input logic           rst_n,
   input logic [A_W-1:0] swallow_o,
   input logic [M_W-1:0] main_o,
   input logic [B_W-1:0] band_o,
   input logic [R_W-1:0] ref_o,
   input logic           sync_pulse,
   input logic           r_load_pulse
);
   // R8
   rload_with_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      r_load_pulse |-> sync_pulse);
   // R8
   sync_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sync_pulse |=> !sync_pulse);
   // R8
   rload_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      r_load_pulse |=> !r_load_pulse);
   // R10
   fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sync_pulse |-> ($stable(swallow_o) && $stable(main_o) && $stable(band_o) && $stable(ref_o)));
   // R3
   ref_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_pulse && !r_load_pulse) |-> $stable(ref_o));
endmodule

bind synth_serial_loader synth_serial_loader_chk #(
   .A_W(A_W), .M_W(M_W), .B_W(B_W), .R_W(R_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .swallow_o(swallow_o), .main_o(main_o),
   .band_o(band_o), .ref_o(ref_o), .sync_pulse(sync_pulse),
   .r_load_pulse(r_load_pulse));

// File: tb/tb_synth_serial_loader.sv
`timescale 1ns/1ps
module tb_synth_serial_loader;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_en = 1'b0, ser_clk = 1'b0, ser_dat = 1'b0;
   logic [6:0]  swallow_o;
   logic [9:0]  main_o;
   logic [1:0]  band_o;
   logic [10:0] ref_o;
   logic sync_pulse, r_load_pulse;

   always #4 clk = ~clk;

   synth_serial_loader dut (
      .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .ser_clk(ser_clk), .ser_dat(ser_dat),
      .swallow_o(swallow_o), .main_o(main_o), .band_o(band_o), .ref_o(ref_o),
      .sync_pulse(sync_pulse), .r_load_pulse(r_load_pulse));

   int n_checks = 0, n_fail = 0, n_sync = 0, n_rld = 0;
   bit finished = 1'b0;
   logic stream [0:39];
   logic [6:0] exp_a = '0;
   logic [9:0] exp_m = '0;
   logic [1:0] exp_b = '0;
   logic [10:0] exp_r = '0;

   always @(negedge clk) begin
      if (sync_pulse)   n_sync++;
      if (r_load_pulse) n_rld++;
   end

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic wait_cyc(input int k);
      repeat (k) @(negedge clk);
   endtask

   task automatic put_fields(input logic [6:0] a, input logic [9:0] m,
                             input logic [1:0] b, input logic [10:0] r);
      logic [29:0] w;
      w = {a, m, b, r};
      for (int i = 0; i < 30; i++) stream[i] = w[29-i];
      for (int i = 30; i < 40; i++) stream[i] = 1'b1;
   endtask

   // model: count of bits taken, with a tied last edge not counted and saturation at 30
   task automatic model(input int n, input bit tie, output int eff);
      eff = tie ? n - 1 : n;
      if (eff > 30) eff = 30;
      if (eff >= 19) begin
         for (int i = 0; i < 7; i++)  exp_a = {exp_a[5:0], stream[i]};
         for (int i = 7; i < 17; i++) exp_m = {exp_m[8:0], stream[i]};
         for (int i = 17; i < 19; i++) exp_b = {exp_b[0], stream[i]};
      end
      if (eff == 30)
         for (int i = 19; i < 30; i++) exp_r = {exp_r[9:0], stream[i]};
   endtask

   task automatic run_frame(input int n, input bit tie, input string req);
      int s0, r0, eff;
      s0 = n_sync; r0 = n_rld;
      ser_en = 1'b1;
      wait_cyc(5);
      for (int i = 0; i < n; i++) begin
         ser_dat = (i < 40) ? stream[i] : 1'b0;
         ser_clk = 1'b1;
         wait_cyc(4);
         ser_clk = 1'b0;
         if (tie && i == n - 1) ser_en = 1'b0;
         wait_cyc(4);
      end
      ser_en = 1'b0;
      wait_cyc(12);
      model(n, tie, eff);
      check(swallow_o == exp_a, req, "swallow", swallow_o, exp_a);
      check(main_o == exp_m, req, "main", main_o, exp_m);
      check(band_o == exp_b, "R7", "band", band_o, exp_b);
      check(ref_o == exp_r, req, "ref", ref_o, exp_r);
      check((n_sync - s0) == ((eff >= 19) ? 1 : 0), "R8", "sync pulses", n_sync - s0, (eff >= 19) ? 1 : 0);
      check((n_rld - r0) == ((eff == 30) ? 1 : 0), "R8", "rload pulses", n_rld - r0, (eff == 30) ? 1 : 0);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_run();
   end

   initial begin
      int s0;
      void'($urandom(32'd20240611));
      wait_cyc(3);
      // R1 reset state
      check(swallow_o == 0 && main_o == 0 && band_o == 0 && ref_o == 0, "R1", "fields", {swallow_o, main_o, band_o, ref_o}, 0);
      check(!sync_pulse && !r_load_pulse, "R1", "strobes", {sync_pulse, r_load_pulse}, 0);
      rst_n = 1'b1;
      wait_cyc(3);
      // R2 full word
      put_fields(7'h5A, 10'h2C3, 2'b10, 11'h4D1);
      run_frame(30, 1'b0, "R2");
      // R3 short word at 19 and at 25
      put_fields(7'h21, 10'h1F0, 2'b01, 11'h7FF);
      run_frame(19, 1'b0, "R3");
      put_fields(7'h0F, 10'h0AA, 2'b11, 11'h123);
      run_frame(25, 1'b0, "R3");
      // R4 too short
      put_fields(7'h7F, 10'h3FF, 2'b00, 11'h000);
      run_frame(18, 1'b0, "R4");
      // R5 extra clocks beyond 30
      put_fields(7'h33, 10'h155, 2'b10, 11'h2AA);
      run_frame(34, 1'b0, "R5");
      // R6 activity with strobe low
      s0 = n_sync;
      for (int i = 0; i < 25; i++) begin
         ser_dat = i[0]; ser_clk = 1'b1; wait_cyc(4); ser_clk = 1'b0; wait_cyc(4);
      end
      wait_cyc(12);
      check(swallow_o == exp_a && main_o == exp_m && ref_o == exp_r, "R6", "fields", swallow_o, exp_a);
      check(n_sync == s0, "R6", "sync pulses", n_sync - s0, 0);
      // R9 clock fall tied to strobe fall
      put_fields(7'h11, 10'h222, 2'b01, 11'h333);
      run_frame(19, 1'b1, "R9");
      put_fields(7'h44, 10'h099, 2'b10, 11'h555);
      run_frame(30, 1'b1, "R9");
      // random words
      for (int k = 0; k < 30; k++) begin
         int n;
         for (int i = 0; i < 40; i++) stream[i] = 1'($urandom % 2);
         n = 10 + int'($urandom % 26);
         run_frame(n, 1'($urandom % 4 == 0), (n >= 30) ? "R2" : "R3");
      end
      finish_run();
   end
endmodule